// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller with Extended Lines

This block collects interrupt requests for up to four processors. Requests are held in one shared pending register. Hardware request inputs set it on a rising edge, and software can write it directly. Each processor has its own mask register and its own force register. For each processor the block picks the highest active line from 1 to 15 and drives that line's number as a 4-bit level. A processor returns an acknowledge that carries a level, and the block then retires that request.

The parameter `EXT_LINE` can enable the upper lines 16 to 31. These lines do not get levels of their own. Any active upper line makes primary line `EXT_LINE` look active for that processor. When a processor acknowledges that primary line, the block claims the lowest upper line that is pending and unmasked for that processor. It clears that line and records its index in a per-processor register, so the handler knows which source it was given. Setting `EXT_LINE` to 0 turns the feature off and leaves only lines 1 to 15.

Software reaches the state through a simple 32-bit register port. The read data is registered and so has one cycle of latency.

Top module: `mpic_ctrl`

## Requirements
- R1: Bit 0 is never implemented. With `EXT_LINE` nonzero the supported set is bits 31:1; with `EXT_LINE` = 0 it is bits 15:1. Writes to pending (offset 0x04), writes to mask and writes to clear (offset 0x0C, a 1 clears the pending bit) only affect supported bits.
- R2: A processor's active set is (pending OR its force) AND its mask, within the supported set. When `EXT_LINE` is nonzero and any of bits 31:16 of that set is nonzero, line `EXT_LINE` is also active for that processor.
- R3: Each `irl` field (processor n at bits 4n+3:4n) is the index of the highest active line from 1 to 15, or 0 when none is active. It is registered and changes on the clock edge after the state change.
- R4: On an acknowledge of level L by processor n, the extended-acknowledge register of processor n becomes 0. If force bit L of processor n is set, only that force bit clears. Otherwise pending bit L clears.
- R5: When L equals a nonzero `EXT_LINE`, the lowest bit from 16 up to 31 that is pending and set in processor n's mask is cleared from pending, and its index is written to processor n's extended-acknowledge register.
- R6: The register map is as follows. 0x04 is pending. 0x08 is the force register of processor 0. 0x10 is status. 0x40+4n is the mask of processor n. 0x80+4n is the force of processor n. 0xC0+4n is the extended acknowledge of processor n. Any other offset, including 0x0C and any n at or above the processor count, reads 0. Read data appears one cycle after the address.
- R7: Status reads the processor count minus one in bits 31:28, `EXT_LINE` in bits 19:16, and `pwd[n]` in bit n. All other bits are 0.
- R8: A synchronous reset clears pending, every mask, force and extended-acknowledge register, and all `irl` outputs.
- R9: When an acknowledge and a register write land in the same cycle, the acknowledge's clear is applied after the write.
- R10: Force registers keep bits 15:1 only. Offsets 0x08 and 0x80 address the same register.
- R11: A rising edge on `irq_in[i]` sets pending bit i if bit i is supported. A level held high does not set it again after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_in | input | 32 | Hardware request lines, rising-edge sensitive |
| ack_vld | input | NCPU | Acknowledge strobe, one per processor |
| ack_lvl | input | 4*NCPU | Acknowledged level, processor n at bits 4n+3:4n |
| pwd | input | NCPU | Power-down flags shown in status |
| irl | output | 4*NCPU | Interrupt level, processor n at bits 4n+3:4n |

## Verification
The hardest situation to reach is an acknowledge of the extended primary line while several upper lines are pending and the processor's mask selects only some of them. The stimulus sets up pending and mask by register writes so that a lower pending line is masked off, or two eligible lines compete. It then checks both the claimed index and the pending bits left behind. A second hard case is an acknowledge that lands in the same cycle as a pending write. A dedicated task raises the write strobe and the acknowledge on the same edge, and the result is read back through the pending register. A second instance built with the extended feature off is driven in parallel, so the narrower supported set is checked under the same stimulus.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  localparam int DW   = 32;
  localparam int LVLW = 4;
  localparam int NPRI = 16;

  function automatic logic [DW-1:0] sup_set(input int ext_line);
    return (ext_line != 0) ? 32'hFFFF_FFFE : 32'h0000_FFFE;
  endfunction

  // highest set index among 15:1, 0 when none
  function automatic logic [LVLW-1:0] top_level(input logic [NPRI-1:0] v);
    logic [LVLW-1:0] r;
    r = '0;
    for (int i = 1; i < NPRI; i++)
      if (v[i]) r = LVLW'(i);
    return r;
  endfunction

  // {found, index} of the lowest set bit among 31:16
  function automatic logic [5:0] first_ext(input logic [DW-1:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = DW - 1; i >= NPRI; i--)
      if (v[i]) r = {1'b1, 5'(i)};
    return r;
  endfunction
endpackage

// File: rtl/mpic_pending.sv
module mpic_pending
  import mpic_pkg::*;
#(
  parameter int EXT_LINE = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_set,
  input  logic          wr_clr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] irq_in,
  input  logic [DW-1:0] ack_clr,
  output logic [DW-1:0] pend
);
  localparam logic [DW-1:0] SUP = sup_set(EXT_LINE);

  logic [DW-1:0] irq_q, base, nxt;

  always_comb begin
    if (wr_set)      base = wdata;
    else if (wr_clr) base = pend & ~wdata;
    else             base = pend;
    // acknowledge clears are applied last
    nxt = (base | (irq_in & ~irq_q)) & ~ack_clr & SUP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      irq_q <= '0;
    end else begin
      pend  <= nxt;
      irq_q <= irq_in;
    end
  end
endmodule

// File: rtl/mpic_cpu_port.sv
module mpic_cpu_port
  import mpic_pkg::*;
#(
  parameter int IDX      = 0,
  parameter int EXT_LINE = 12,
  parameter int AW       = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic [DW-1:0]   pend,
  input  logic            ack_vld,
  input  logic [LVLW-1:0] ack_lvl,
  output logic [DW-1:0]   mask_q,
  output logic [NPRI-1:0] force_q,
  output logic [4:0]      xack_q,
  output logic [DW-1:0]   pend_clr,
  output logic [LVLW-1:0] irl_q
);
  localparam logic [DW-1:0]   SUP    = sup_set(EXT_LINE);
  localparam bit              EXT_ON = (EXT_LINE != 0);
  localparam logic [LVLW-1:0] EXT_L  = LVLW'(EXT_LINE);
  localparam logic [AW-1:0]   MASK_A = AW'(64 + 4 * IDX);
  localparam logic [AW-1:0]   FRC_A  = AW'(128 + 4 * IDX);
  localparam logic [AW-1:0]   FRC0_A = AW'(8);

  logic            mhit, fhit, frc_hit, take_ext;
  logic [5:0]      scan;
  logic [DW-1:0]   lvl_bit, mask_nxt, active;
  logic [NPRI-1:0] force_nxt, act16;
  logic [4:0]      xack_nxt;

  always_comb begin
    mhit     = reg_wr && (reg_addr == MASK_A);
    fhit     = reg_wr && ((reg_addr == FRC_A) || ((IDX == 0) && (reg_addr == FRC0_A)));
    lvl_bit  = 32'd1 << ack_lvl;
    scan     = first_ext(pend & mask_q);
    frc_hit  = force_q[ack_lvl];
    take_ext = EXT_ON && ack_vld && (ack_lvl == EXT_L) && scan[5];

    pend_clr = '0;
    if (ack_vld && !frc_hit) pend_clr = lvl_bit;
    if (take_ext)            pend_clr = pend_clr | (32'd1 << scan[4:0]);

    force_nxt = fhit ? (reg_wdata[NPRI-1:0] & 16'hFFFE) : force_q;
    if (ack_vld && frc_hit) force_nxt[ack_lvl] = 1'b0;

    mask_nxt = mhit ? (reg_wdata & SUP) : mask_q;
    xack_nxt = ack_vld ? (take_ext ? scan[4:0] : 5'd0) : xack_q;

    active = (pend | {16'b0, force_q}) & mask_q & SUP;
    act16  = active[NPRI-1:0];
    if (EXT_ON && (|active[DW-1:NPRI])) act16[EXT_L] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      force_q <= '0;
      xack_q  <= '0;
      irl_q   <= '0;
    end else begin
      mask_q  <= mask_nxt;
      force_q <= force_nxt;
      xack_q  <= xack_nxt;
      irl_q   <= top_level(act16);
    end
  end
endmodule

// File: rtl/mpic_regread.sv
module mpic_regread
  import mpic_pkg::*;
#(
  parameter int NCPU     = 4,
  parameter int EXT_LINE = 12,
  parameter int AW       = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      pend,
  input  logic [NCPU*DW-1:0] mask_all,
  input  logic [NCPU*16-1:0] force_all,
  input  logic [NCPU*5-1:0]  xack_all,
  input  logic [NCPU-1:0]    pwd,
  output logic [DW-1:0]      reg_rdata
);
  logic [DW-1:0] status, rd_nxt;
  int            a, n;

  always_comb begin
    status        = '0;
    status[31:28] = 4'(NCPU - 1);
    status[19:16] = 4'(EXT_LINE);
    status[NCPU-1:0] = pwd;

    a      = int'(reg_addr);
    n      = (a % 64) / 4;
    rd_nxt = '0;
    if (a == 4)       rd_nxt = pend;
    else if (a == 8)  rd_nxt = {16'b0, force_all[15:0]};
    else if (a == 16) rd_nxt = status;
    else if ((a % 4 == 0) && (n < NCPU)) begin
      if (a >= 64 && a < 128)       rd_nxt = mask_all[n*DW +: DW];
      else if (a >= 128 && a < 192) rd_nxt = {16'b0, force_all[n*16 +: 16]};
      else if (a >= 192 && a < 256) rd_nxt = {27'b0, xack_all[n*5 +: 5]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end
endmodule

// File: rtl/mpic_ctrl.sv
module mpic_ctrl
  import mpic_pkg::*;
#(
  parameter int NCPU     = 4,
  parameter int EXT_LINE = 12,
  parameter int AW       = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic [DW-1:0]        irq_in,
  input  logic [NCPU-1:0]      ack_vld,
  input  logic [NCPU*LVLW-1:0] ack_lvl,
  input  logic [NCPU-1:0]      pwd,
  output logic [NCPU*LVLW-1:0] irl
);
  logic [DW-1:0]      pend_q, ack_clr;
  logic [NCPU*DW-1:0] mask_all, clr_all;
  logic [NCPU*16-1:0] force_all;
  logic [NCPU*5-1:0]  xack_all;

  always_comb begin
    ack_clr = '0;
    for (int i = 0; i < NCPU; i++) ack_clr = ack_clr | clr_all[i*DW +: DW];
  end

  mpic_pending #(.EXT_LINE(EXT_LINE)) u_pend (
    .clk(clk), .rst(rst),
    .wr_set(reg_wr && (reg_addr == AW'(4))),
    .wr_clr(reg_wr && (reg_addr == AW'(12))),
    .wdata(reg_wdata), .irq_in(irq_in), .ack_clr(ack_clr), .pend(pend_q)
  );

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    mpic_cpu_port #(.IDX(g), .EXT_LINE(EXT_LINE), .AW(AW)) u_port (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .pend(pend_q),
      .ack_vld(ack_vld[g]), .ack_lvl(ack_lvl[g*LVLW +: LVLW]),
      .mask_q(mask_all[g*DW +: DW]), .force_q(force_all[g*16 +: 16]),
      .xack_q(xack_all[g*5 +: 5]), .pend_clr(clr_all[g*DW +: DW]),
      .irl_q(irl[g*LVLW +: LVLW])
    );
  end

  mpic_regread #(.NCPU(NCPU), .EXT_LINE(EXT_LINE), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .pend(pend_q),
    .mask_all(mask_all), .force_all(force_all), .xack_all(xack_all),
    .pwd(pwd), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/mpic_ctrl_chk.sv
module mpic_ctrl_chk #(
  parameter int NCPU     = 4,
  parameter int EXT_LINE = 12,
  parameter int AW       = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic [AW-1:0]      reg_addr,
  input logic [31:0]        reg_rdata,
  input logic [31:0]        irq_in,
  input logic [NCPU-1:0]    ack_vld,
  input logic [NCPU*4-1:0]  ack_lvl,
  input logic [NCPU*4-1:0]  irl,
  input logic [31:0]        pend,
  input logic [NCPU*32-1:0] mask_all,
  input logic [NCPU*16-1:0] force_all,
  input logic [NCPU*5-1:0]  xack_all
);
  assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == AW'(32)) |=> (reg_rdata == 32'd0));

  assert_status_fields_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == AW'(16)) |=> (reg_rdata[31:28] == 4'(NCPU - 1) && reg_rdata[19:16] == 4'(EXT_LINE)));

  for (genvar n = 0; n < NCPU; n++) begin : g_c
    assert_masked_idle_R2: assert property (@(posedge clk) disable iff (rst)
      (mask_all[n*32 +: 32] == 32'd0) |=> (irl[n*4 +: 4] == 4'd0));

    assert_force_retire_R4: assert property (@(posedge clk) disable iff (rst)
      (ack_vld[n] && !reg_wr && force_all[n*16 + int'(ack_lvl[n*4 +: 4])])
      |=> !force_all[n*16 + int'($past(ack_lvl[n*4 +: 4]))]);

    assert_pend_retire_R4: assert property (@(posedge clk) disable iff (rst)
      (ack_vld[n] && !reg_wr && irq_in == 32'd0 && !force_all[n*16 + int'(ack_lvl[n*4 +: 4])])
      |=> !pend[int'($past(ack_lvl[n*4 +: 4]))]);

    assert_xack_cleared_R4: assert property (@(posedge clk) disable iff (rst)
      (ack_vld[n] && (EXT_LINE == 0 || ack_lvl[n*4 +: 4] != 4'(EXT_LINE)))
      |=> (xack_all[n*5 +: 5] == 5'd0));

    if (EXT_LINE != 0) begin : g_ext
      assert_claim_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (ack_vld[n] && ack_lvl[n*4 +: 4] == 4'(EXT_LINE) && irq_in == 32'd0 && !reg_wr)
        |=> (xack_all[n*5 +: 5] == 5'd0 || !pend[xack_all[n*5 +: 5]]));
    end
  end
endmodule

bind mpic_ctrl mpic_ctrl_chk #(.NCPU(NCPU), .EXT_LINE(EXT_LINE), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .irq_in(irq_in), .ack_vld(ack_vld), .ack_lvl(ack_lvl), .irl(irl),
  .pend(pend_q), .mask_all(mask_all), .force_all(force_all), .xack_all(xack_all)
);

// File: tb/mpic_ctrl_bench.sv
`timescale 1ns/1ps
module mpic_ctrl_bench;
  localparam int NCPU = 4;
  localparam int EXT  = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'hFC;
  logic [31:0] reg_wdata = '0;
  logic [31:0] irq_in = '0;
  logic [3:0]  ack_vld = '0;
  logic [15:0] ack_lvl = '0;
  logic [3:0]  pwd = 4'b0101;
  logic [31:0] rdata, rdata_nx;
  logic [15:0] irl, irl_nx;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mpic_ctrl #(.NCPU(NCPU), .EXT_LINE(EXT), .AW(8)) u_mpic_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .irq_in(irq_in), .ack_vld(ack_vld), .ack_lvl(ack_lvl),
    .pwd(pwd), .irl(irl));

  mpic_ctrl #(.NCPU(NCPU), .EXT_LINE(0), .AW(8)) u_mpic_ctrl_noext (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_nx), .irq_in(irq_in), .ack_vld(ack_vld), .ack_lvl(ack_lvl),
    .pwd(pwd), .irl(irl_nx));

  // table: pending value, mask of CPU 0, expected level of CPU 0 (R3, R2, R1)
  localparam int NV = 9;
  localparam logic [31:0] TV_PEND [NV] = '{32'h0000_0002, 32'h0000_8002, 32'h0000_8002,
    32'h0001_0000, 32'h0001_0010, 32'h0001_2000, 32'h0000_0001, 32'h0001_0000, 32'h0};
  localparam logic [31:0] TV_MASK [NV] = '{32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'h0000_0006,
    32'h0001_0000, 32'h0001_0000, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0000_FFFE, 32'hFFFF_FFFE};
  localparam logic [3:0] TV_LVL [NV] = '{4'd1, 4'd15, 4'd1, 4'd12, 4'd12, 4'd13, 4'd0, 4'd0, 4'd0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 8'hFC;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] dn);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = rdata; dn = rdata_nx; reg_addr = 8'hFC;
  endtask

  task automatic ack(input int cpu, input logic [3:0] l);
    @(negedge clk); ack_vld[cpu] = 1'b1; ack_lvl[cpu*4 +: 4] = l;
    @(negedge clk); ack_vld = '0;
  endtask

  task automatic wr_ack(input logic [7:0] a, input logic [31:0] d, input int cpu, input logic [3:0] l);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    ack_vld[cpu] = 1'b1; ack_lvl[cpu*4 +: 4] = l;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 8'hFC; ack_vld = '0;
  endtask

  initial begin
    logic [31:0] d, dn;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8: reset state
    chk("R8 irl after reset", {16'b0, irl}, 32'h0);
    for (int c = 0; c < NCPU; c++) begin
      rd(8'h40 + 8'(4*c), d, dn); chk("R8 mask after reset", d, 32'h0);
      rd(8'h80 + 8'(4*c), d, dn); chk("R8 force after reset", d, 32'h0);
      rd(8'hC0 + 8'(4*c), d, dn); chk("R8 ext-ack after reset", d, 32'h0);
    end

    // R3 / R2 table walk
    for (int i = 0; i < NV; i++) begin
      wr(8'h40, TV_MASK[i]);
      wr(8'h04, TV_PEND[i]);
      @(negedge clk);
      chk("R3 table level cpu0", {28'b0, irl[3:0]}, {28'b0, TV_LVL[i]});
    end
    wr(8'h40, 32'h0);

    // R1: supported sets
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d, dn);
    chk("R1 pending write ext on", d, 32'hFFFF_FFFE);
    chk("R1 pending write ext off", dn, 32'h0000_FFFE);
    wr(8'h0C, 32'h0000_0F00);
    rd(8'h04, d, dn);
    chk("R1 clear write", d, 32'hFFFF_F0FE);
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, d, dn);
    chk("R1 mask write ext on", d, 32'hFFFF_FFFE);
    chk("R1 mask write ext off", dn, 32'h0000_FFFE);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h44, 32'h0);
    rd(8'h04, d, dn);
    chk("R1 clear all", d, 32'h0);

    // R10: force width and alias
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h80, d, dn);
    chk("R10 force via alias", d, 32'h0000_FFFE);
    rd(8'h08, d, dn);
    chk("R10 force read 0x08", d, 32'h0000_FFFE);
    wr(8'h80, 32'h0);

    // R7 status, R6 unmapped
    rd(8'h10, d, dn);
    chk("R7 status ext on", d, 32'h300C_0005);
    chk("R7 status ext off", dn, 32'h3000_0005);
    rd(8'h20, d, dn);
    chk("R6 unmapped 0x20", d, 32'h0);
    rd(8'h0C, d, dn);
    chk("R6 clear reg reads zero", d, 32'h0);
    rd(8'hD0, d, dn);
    chk("R6 ext-ack beyond cpu count", d, 32'h0);

    // R4: force-before-pending ordering on CPU 1
    wr(8'h84, 32'h20);
    wr(8'h04, 32'h20);
    wr(8'h44, 32'h20);
    @(negedge clk);
    chk("R3 level cpu1", {28'b0, irl[7:4]}, 32'd5);
    ack(1, 4'd5);
    rd(8'h84, d, dn);
    chk("R4 force bit cleared first", d, 32'h0);
    rd(8'h04, d, dn);
    chk("R4 pending kept while force taken", d, 32'h20);
    ack(1, 4'd5);
    rd(8'h04, d, dn);
    chk("R4 pending cleared second", d, 32'h0);
    chk("R3 level cpu1 drops", {28'b0, irl[7:4]}, 32'd0);
    wr(8'h44, 32'h0);

    // R5: claim lowest eligible extended line on CPU 2
    wr(8'h04, 32'h0005_0000);
    wr(8'h48, 32'h0004_1000);
    @(negedge clk);
    chk("R2 funnel to primary cpu2", {28'b0, irl[11:8]}, 32'd12);
    ack(2, 4'd12);
    rd(8'hC8, d, dn);
    chk("R5 claimed masked-in line", d, 32'd18);
    rd(8'h04, d, dn);
    chk("R5 claimed bit cleared only", d, 32'h0001_0000);
    chk("R2 cpu2 idle after claim", {28'b0, irl[11:8]}, 32'd0);
    ack(2, 4'd3);
    rd(8'hC8, d, dn);
    chk("R4 ext-ack reset by other level", d, 32'h0);
    wr(8'h04, 32'h8003_0000);
    wr(8'h48, 32'hFFFF_1000);
    ack(2, 4'd12);
    rd(8'hC8, d, dn);
    chk("R5 lowest of two wins", d, 32'd16);
    rd(8'h04, d, dn);
    chk("R5 pending after lowest claim", d, 32'h8002_0000);

    // R8: reset mid-run clears ext-ack and mask
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(8'hC8, d, dn);
    chk("R8 ext-ack cleared by reset", d, 32'h0);
    rd(8'h48, d, dn);
    chk("R8 mask cleared by reset", d, 32'h0);
    rd(8'h04, d, dn);
    chk("R8 pending cleared by reset", d, 32'h0);

    // R9: acknowledge and pending write in one cycle
    wr(8'h40, 32'h8);
    wr_ack(8'h04, 32'h0000_0108, 0, 4'd3);
    rd(8'h04, d, dn);
    chk("R9 ack applied after write", d, 32'h0000_0100);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h40, 32'h0);

    // R11: edge-sensitive request lines
    @(negedge clk); irq_in = 32'h0000_0081;
    repeat (3) @(negedge clk);
    rd(8'h04, d, dn);
    chk("R11 rising edge sets supported bit", d, 32'h80);
    chk("R11 rising edge ext off", dn, 32'h80);
    wr(8'h0C, 32'h80);
    rd(8'h04, d, dn);
    chk("R11 held level does not re-set", d, 32'h0);
    @(negedge clk); irq_in = 32'h0002_0081;
    repeat (2) @(negedge clk);
    rd(8'h04, d, dn);
    chk("R11 upper line ext on", d, 32'h0002_0000);
    chk("R11 upper line ext off", dn, 32'h0);
    irq_in = '0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule